// File: doc/BRIEF.md
# System Mode Register with Internal Clock Prescaler

This block holds one 8-bit system control register and the internal clock-enable generator that the register programs. The register is reached over a simple register bus: an address, write data, a write strobe and a read-data return. Apart from the clock ratio, the register carries four unrelated control bits. Two of them choose where the system stack and the user stack live. One enables the external bus request input. The last one asks the memory-interface pads to go to high impedance. The block drives each of these bits out as a control level. It does not implement the logic behind them.

The generator produces a one-cycle enable pulse from the oscillator clock `clk`. The clock first passes through an optional halving stage and then through a counter that divides by a programmable factor from one to eight. Downstream logic treats the pulse as the tick of the internal clock. A new ratio written to the register is not applied at once. It is taken up only when the divider chain reaches its terminal count. Because of this, a ratio change never produces a truncated or stretched interval between enable pulses.

Top module: `sysmode_ctl`

## Requirements
- R1: After synchronous reset the register reads E0h: both stack selects are 1, the halving bit is 1, the prescaler field is 000, and the bus-request and high-impedance enables are 0.
- R2: A write with `reg_we` high and `reg_addr` equal to EBh loads all eight bits of `reg_wdata`, and the new value is visible on `reg_rdata` and on the control outputs in the following cycle.
- R3: A write to any other address leaves the register unchanged, and a read of any other address returns 00h.
- R4: The field layout is as follows. Bit 7 drives `sys_stack_int` and bit 6 drives `usr_stack_int`. Bit 5 is the halving select. Bits 4:2 hold the prescaler field. Bit 1 drives `bus_req_en` and bit 0 drives `addr_hiz`. A read at EBh returns the bits in this layout.
- R5: `clk_en` is a pulse one cycle wide that repeats every (halve ? 2 : 1) × (field + 1) cycles of `clk`. A field value of 000 divides by 1 and 111 divides by 8. With a total ratio of 1, `clk_en` stays high.
- R6: The reset setting produces an enable interval of 2 cycles.
- R7: A ratio written to the register takes effect only at the next enable pulse. The interval that is in progress when the write occurs completes at the old ratio. Every later interval uses the new ratio, so no interval of any other length appears.
- R8: All 16 combinations of the halving bit and the prescaler field produce their stated interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_addr | input | 8 | Register bus address |
| reg_wdata | input | 8 | Register bus write data |
| reg_we | input | 1 | Register bus write strobe |
| reg_rdata | output | 8 | Register bus read data (combinational) |
| clk_en | output | 1 | Internal clock enable pulse |
| sys_stack_int | output | 1 | System stack held internally when 1 |
| usr_stack_int | output | 1 | User stack held internally when 1 |
| bus_req_en | output | 1 | External bus request input enabled when 1 |
| addr_hiz | output | 1 | Memory interface pads forced to high impedance when 1 |

## Verification
The divider is driven through all 16 halving/prescaler settings in ascending order. Each setting is written right after an enable pulse, and the bench predicts every following interval. This order separates three cases: an interval that finishes at the old ratio, a change that takes effect too early, and a change that takes effect one pulse too late. The step from a ratio of 1 to a ratio of 2 is the case where a pulse coincides with the write edge. The write values also vary the stack, bus-request and high-impedance bits, so a mis-wired field shows up on the control outputs. A write to a neighbouring address checks that the register ignores it.

// File: rtl/sysmode_pkg.sv
package sysmode_pkg;

    localparam int PRS_W     = 3;
    localparam int REG_W     = 8;
    localparam int MAX_RATIO = 2 * (1 << PRS_W);
    localparam int GAP_W     = $clog2(MAX_RATIO + 1) + 1;

    localparam logic [REG_W-1:0] MODE_RESET = 8'hE0;

    typedef struct packed {
        logic             sys_stk;
        logic             usr_stk;
        logic             halve;
        logic [PRS_W-1:0] presc;
        logic             breq;
        logic             hiz;
    } mode_t;

    typedef struct packed {
        logic             halve;
        logic [PRS_W-1:0] presc;
    } ratio_t;

    function automatic int ratio_of(input ratio_t r);
        return (r.halve ? 2 : 1) * (int'(r.presc) + 1);
    endfunction

endpackage

// File: rtl/mode_reg.sv
module mode_reg
    import sysmode_pkg::*;
#(
    parameter int               ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] MODE_ADDR = 8'hEB
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic [REG_W-1:0]  wdata,
    input  logic              we,
    output logic [REG_W-1:0]  rdata,
    output mode_t             mode
);
    logic hit;

    assign hit = (addr == MODE_ADDR);

    always_ff @(posedge clk) begin
        if (rst) begin
            mode <= mode_t'(MODE_RESET);
        end else if (we && hit) begin
            mode <= mode_t'(wdata);
        end
    end

    assign rdata = hit ? REG_W'(mode) : '0;
endmodule

// File: rtl/half_stage.sv
module half_stage (
    input  logic clk,
    input  logic rst,
    input  logic enable,
    input  logic restart,
    output logic tick
);
    logic phase;

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            phase <= 1'b0;
        end else if (enable) begin
            phase <= ~phase;
        end
    end

    // Bypassed stage passes every cycle; active stage passes every second one.
    assign tick = !enable || phase;
endmodule

// File: rtl/presc_stage.sv
module presc_stage #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic [W-1:0] limit,
    output logic         term
);
    logic [W-1:0] count;

    assign term = tick && (count == limit);

    always_ff @(posedge clk) begin
        if (rst || term) begin
            count <= '0;
        end else if (tick) begin
            count <= count + 1'b1;
        end
    end
endmodule

// File: rtl/sysmode_ctl.sv
module sysmode_ctl
    import sysmode_pkg::*;
#(
    parameter int               ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] MODE_ADDR = 8'hEB
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [7:0]        reg_wdata,
    input  logic              reg_we,
    output logic [7:0]        reg_rdata,
    output logic              clk_en,
    output logic              sys_stack_int,
    output logic              usr_stack_int,
    output logic              bus_req_en,
    output logic              addr_hiz
);
    mode_t  mode_q;
    ratio_t active;
    logic   tick;
    logic   term;
    logic   pulse_q;

    mode_reg #(.ADDR_W(ADDR_W), .MODE_ADDR(MODE_ADDR)) u_reg (
        .clk   (clk),
        .rst   (rst),
        .addr  (reg_addr),
        .wdata (reg_wdata),
        .we    (reg_we),
        .rdata (reg_rdata),
        .mode  (mode_q)
    );

    half_stage u_half (
        .clk     (clk),
        .rst     (rst),
        .enable  (active.halve),
        .restart (term),
        .tick    (tick)
    );

    presc_stage #(.W(PRS_W)) u_presc (
        .clk   (clk),
        .rst   (rst),
        .tick  (tick),
        .limit (active.presc),
        .term  (term)
    );

    // The ratio in use is refreshed only at terminal count.
    always_ff @(posedge clk) begin
        if (rst) begin
            active  <= '{halve: MODE_RESET[5], presc: MODE_RESET[4:2]};
            pulse_q <= 1'b0;
        end else begin
            pulse_q <= term;
            if (term) begin
                active <= '{halve: mode_q.halve, presc: mode_q.presc};
            end
        end
    end

    assign clk_en        = pulse_q;
    assign sys_stack_int = mode_q.sys_stk;
    assign usr_stack_int = mode_q.usr_stk;
    assign bus_req_en    = mode_q.breq;
    assign addr_hiz      = mode_q.hiz;
endmodule

// File: rtl/sysmode_ctl_chk.sv
module sysmode_ctl_chk
    import sysmode_pkg::*;
#(
    parameter int               ADDR_W    = 8,
    parameter logic [ADDR_W-1:0] MODE_ADDR = 8'hEB
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [7:0]        reg_wdata,
    input logic              reg_we,
    input logic [7:0]        reg_rdata,
    input logic              clk_en,
    input logic              sys_stack_int,
    input logic              usr_stack_int,
    input logic              bus_req_en,
    input logic              addr_hiz,
    input logic [7:0]        mode_bits
);
    logic [7:0]       mode_d;
    ratio_t           snap;
    logic [GAP_W-1:0] gap;
    logic             armed;

    always_ff @(posedge clk) begin
        if (rst) begin
            gap    <= '0;
            armed  <= 1'b0;
            snap   <= '0;
            mode_d <= MODE_RESET;
        end else begin
            mode_d <= mode_bits;
            if (clk_en) begin
                gap   <= GAP_W'(1);
                armed <= 1'b1;
                snap  <= '{halve: mode_d[5], presc: mode_d[4:2]};
            end else if (gap != '1) begin
                gap <= gap + 1'b1;
            end
        end
    end

    p_reset_val_r1: assert property (@(posedge clk)
        rst |=> (mode_bits == MODE_RESET));

    p_write_load_r2: assert property (@(posedge clk) disable iff (rst)
        (reg_we && reg_addr == MODE_ADDR) |=> (mode_bits == $past(reg_wdata)));

    p_other_addr_r3: assert property (@(posedge clk) disable iff (rst)
        !(reg_we && reg_addr == MODE_ADDR) |=> $stable(mode_bits));

    p_read_layout_r4: assert property (@(posedge clk) disable iff (rst)
        (reg_addr == MODE_ADDR) |-> (reg_rdata[7] == sys_stack_int && reg_rdata[6] == usr_stack_int
                                     && reg_rdata[1] == bus_req_en && reg_rdata[0] == addr_hiz));

    // R7: the interval ending here uses the ratio captured at the previous pulse.
    p_interval_r5: assert property (@(posedge clk) disable iff (rst)
        (armed && clk_en) |-> (int'(gap) == ratio_of(snap)));
endmodule

bind sysmode_ctl sysmode_ctl_chk #(.ADDR_W(ADDR_W), .MODE_ADDR(MODE_ADDR)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .reg_addr      (reg_addr),
    .reg_wdata     (reg_wdata),
    .reg_we        (reg_we),
    .reg_rdata     (reg_rdata),
    .clk_en        (clk_en),
    .sys_stack_int (sys_stack_int),
    .usr_stack_int (usr_stack_int),
    .bus_req_en    (bus_req_en),
    .addr_hiz      (addr_hiz),
    .mode_bits     (mode_q)
);

// File: tb/sim_sysmode_ctl.sv
module sim_sysmode_ctl;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] reg_addr = 8'h00;
    logic [7:0] reg_wdata = 8'h00;
    logic       reg_we = 1'b0;
    logic [7:0] reg_rdata;
    logic       clk_en, sys_stack_int, usr_stack_int, bus_req_en, addr_hiz;

    int    n_run = 0;
    int    n_fail = 0;
    int    cyc = 0;
    int    exp_q[$];
    string tag_q[$];
    event  popped;
    bit    run = 1'b0;
    bit    has_prev = 1'b0;
    int    since = 0;
    int    cur = 2;
    int    e_val;
    string e_tag;

    always #4 clk = ~clk;

    sysmode_ctl u0 (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we),
        .reg_rdata(reg_rdata), .clk_en(clk_en), .sys_stack_int(sys_stack_int),
        .usr_stack_int(usr_stack_int), .bus_req_en(bus_req_en), .addr_hiz(addr_hiz)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int model_ratio(input logic [7:0] v);
        int r;
        r = int'(v[4:2]) + 1;
        if (v[5]) r = r * 2;
        return r;
    endfunction

    task automatic push(input int v, input string t);
        exp_q.push_back(v);
        tag_q.push_back(t);
    endtask

    // Monitor: measures each enable interval and compares it with the scoreboard.
    always @(negedge clk) begin
        if (run && !rst) begin
            if (clk_en) begin
                if (has_prev) begin
                    if (exp_q.size() == 0) begin
                        chk(1'b0, "R5 unexpected pulse", since + 1, 0);
                    end else begin
                        e_val = exp_q.pop_front();
                        e_tag = tag_q.pop_front();
                        chk(since + 1 == e_val, e_tag, since + 1, e_val);
                    end
                    -> popped;
                end
                has_prev = 1'b1;
                since    = 0;
            end else begin
                since++;
            end
        end
    end

    // Driver: writes one setting right after a pulse and predicts the intervals.
    task automatic apply(input logic [7:0] v);
        int oldr;
        int newr;
        oldr = cur;
        newr = model_ratio(v);
        while (exp_q.size() != 0) @(popped);
        reg_addr  = 8'hEB;
        reg_wdata = v;
        reg_we    = 1'b1;
        push(oldr, "R7 interval in progress keeps old ratio");
        if (oldr == 1) push(oldr, "R7 pulse on write edge keeps old ratio");
        push(newr, "R8 new ratio first interval");
        push(newr, "R5 new ratio repeated");
        push(newr, "R8 new ratio steady");
        @(negedge clk);
        reg_we = 1'b0;
        chk(reg_rdata == v, "R2 readback", reg_rdata, v);
        chk({sys_stack_int, usr_stack_int, bus_req_en, addr_hiz} == {v[7], v[6], v[1], v[0]},
            "R4 control outputs", {sys_stack_int, usr_stack_int, bus_req_en, addr_hiz},
            {v[7], v[6], v[1], v[0]});
        while (exp_q.size() > 1) @(popped);
        cur = newr;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000) begin
            n_fail++;
            $display("FAIL R5 watchdog expired actual=%0d expected=%0d", cyc, 50000);
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        reg_addr = 8'hEB;
        @(negedge clk);
        // R1 reset state
        chk(reg_rdata == 8'hE0, "R1 reset value", reg_rdata, 8'hE0);
        chk({sys_stack_int, usr_stack_int, bus_req_en, addr_hiz} == 4'b1100, "R1 reset outputs",
            {sys_stack_int, usr_stack_int, bus_req_en, addr_hiz}, 4'b1100);

        // R3 neighbouring address is ignored
        reg_addr = 8'hEA; reg_wdata = 8'hFF; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
        chk(reg_rdata == 8'h00, "R3 read of other address", reg_rdata, 0);
        reg_addr = 8'hEB;
        #1;
        chk(reg_rdata == 8'hE0, "R3 register unchanged", reg_rdata, 8'hE0);
        chk(bus_req_en == 1'b0 && addr_hiz == 1'b0, "R3 outputs unchanged",
            {bus_req_en, addr_hiz}, 0);

        // R6 reset ratio is 2
        push(2, "R6 reset interval");
        run = 1'b1;

        // R8 all halving/prescaler combinations, other bits varied
        for (int d = 0; d < 2; d++) begin
            for (int p = 0; p < 8; p++) begin
                logic [7:0] v;
                v = {p[1:0], d[0], p[2:0], p[2], d[0]};
                apply(v);
            end
        end
        apply(8'hE0);
        while (exp_q.size() != 0) @(popped);
        run = 1'b0;

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule